// File: doc/BRIEF.md
# Pseudo-Random QPSK Symbol Generator

This block produces an endless stream of QPSK test symbols for a frequency-domain transmit chain. A 16-bit shift register with XOR feedback makes the pseudo-random bits. Each step of the register gives one whole symbol: its top bit sets the sign of the in-phase part and the bit below it sets the sign of the quadrature part. Each part is a signed 16-bit fixed-point value of magnitude 23170, which is about 0.707 in Q1.15. The modulation is always QPSK.

The consumer accepts symbols with a valid/ready handshake. The register advances only when a symbol is accepted, and otherwise holds the current symbol. A seed port lets the consumer restart the sequence from any state. An all-zero seed is replaced by 16'h0001, so the register can never lock up. After a synchronous reset the register holds 16'hACE1, and the stream becomes valid one cycle after reset is released.

Top module: `lfsr_qpsk_src`

## Requirements
- R1: While `rst` is high on a rising edge, the register is set to 16'hACE1 and `symValid` is low in the next cycle. The first symbol after reset is therefore I = -23170, Q = +23170.
- R2: Once a rising edge has sampled `rst` low, `symValid` is high in every later cycle in which `seedLoad` is low.
- R3: `symI` is set by register bit 15 and `symQ` by register bit 14. A bit of 0 gives +23170 and a bit of 1 gives -23170, for each part on its own.
- R4: On a rising edge where `symValid` and `symReady` are both high, the register s becomes {s[14:0], s[15]^s[13]^s[12]^s[10]}. This is the polynomial x^16+x^14+x^13+x^11+1. As a result, the new I bit equals the old Q bit.
- R5: On an edge where the handshake does not complete, the register and both outputs keep their values.
- R6: When `seedLoad` is high, `symValid` is low in that cycle and the register takes `seedValue` at the edge, with no step even if `symReady` is high. The next symbol comes from the new seed.
- R7: A load of 16'h0000 puts 16'h0001 into the register, so the next symbol is I = +23170, Q = +23170.
- R8: Starting from any nonzero state, the output sequence comes back to its starting symbol after exactly 65535 accepted symbols, with every symbol in between following R4.
- R9: Reset takes priority over a seed load in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous reset, active high |
| seedLoad | input | 1 | Load `seedValue` into the register at the next edge |
| seedValue | input | 16 | Seed to load (zero is replaced by 1) |
| symReady | input | 1 | Consumer accepts the current symbol |
| symValid | output | 1 | Current symbol is offered |
| symI | output | 16 | Signed in-phase sample |
| symQ | output | 16 | Signed quadrature sample |

## Verification
The hardest behaviour to reach from the ports is the wrap of the full sequence. Proving that the register returns to its start only after 65535 accepted symbols needs one uninterrupted run of accepted handshakes across the whole period. The stimulus first loads a known seed. It then holds `symReady` high for 65535 cycles, with a scoreboard comparing every symbol along the way. Finally it checks that the symbol after the run matches the one captured just after the load. A zero seed, a load that coincides with `symReady`, and a reset that coincides with a load are each driven directly, to reach the override and priority rules.

// File: rtl/lfsr_qpsk_pkg.sv
package lfsr_qpsk_pkg;

  // Strobes from control to datapath
  typedef struct packed {
    logic load;   // take the seed this edge
    logic step;   // advance the register this edge
  } lfsrCtl_t;

endpackage

// File: rtl/lfsr_qpsk_map.sv
module lfsr_qpsk_map #(
  parameter int SAMPLE_W = 16,
  parameter int AMP      = 23170
) (
  input  logic                       bitIn,
  output logic signed [SAMPLE_W-1:0] sample
);
  localparam logic signed [SAMPLE_W-1:0] POS_LVL = SAMPLE_W'(AMP);
  localparam logic signed [SAMPLE_W-1:0] NEG_LVL = -POS_LVL;

  assign sample = bitIn ? NEG_LVL : POS_LVL;
endmodule

// File: rtl/lfsr_qpsk_ctrl.sv
module lfsr_qpsk_ctrl
  import lfsr_qpsk_pkg::*;
(
  input  logic     clk,
  input  logic     rst,
  input  logic     seedLoad,
  input  logic     symReady,
  output logic     symValid,
  output lfsrCtl_t ctl
);
  logic validReg;

  always_ff @(posedge clk) begin
    if (rst) validReg <= 1'b0;
    else     validReg <= 1'b1;
  end

  // A symbol being replaced by a load is never offered
  assign symValid = validReg & ~seedLoad;

  always_comb begin
    ctl.load = seedLoad & ~rst;
    ctl.step = symValid & symReady & ~rst;
  end
endmodule

// File: rtl/lfsr_qpsk_dp.sv
module lfsr_qpsk_dp
  import lfsr_qpsk_pkg::*;
#(
  parameter int                 STATE_W    = 16,
  parameter int                 SAMPLE_W   = 16,
  parameter logic [STATE_W-1:0] TAPS       = 16'hB400,
  parameter logic [STATE_W-1:0] RESET_SEED = 16'hACE1,
  parameter int                 AMP        = 23170
) (
  input  logic                       clk,
  input  logic                       rst,
  input  lfsrCtl_t                   ctl,
  input  logic [STATE_W-1:0]         seedValue,
  output logic signed [SAMPLE_W-1:0] symI,
  output logic signed [SAMPLE_W-1:0] symQ
);
  localparam int                 NUM_PARTS = 2;
  localparam logic [STATE_W-1:0] SAFE_SEED = STATE_W'(1);

  logic [STATE_W-1:0]         state;
  logic [STATE_W-1:0]         nextState;
  logic [STATE_W-1:0]         seedFixed;
  logic                       feedback;
  logic signed [SAMPLE_W-1:0] parts [NUM_PARTS];

  assign feedback  = ^(state & TAPS);
  assign nextState = {state[STATE_W-2:0], feedback};
  assign seedFixed = (seedValue == '0) ? SAFE_SEED : seedValue;

  always_ff @(posedge clk) begin
    if (rst)           state <= RESET_SEED;
    else if (ctl.load) state <= seedFixed;
    else if (ctl.step) state <= nextState;
  end

  // Part 0 (I) from the top bit, part 1 (Q) from the next one down
  for (genvar k = 0; k < NUM_PARTS; k++) begin : g_part
    lfsr_qpsk_map #(.SAMPLE_W(SAMPLE_W), .AMP(AMP)) u_map (
      .bitIn (state[STATE_W-1-k]),
      .sample(parts[k])
    );
  end

  assign symI = parts[0];
  assign symQ = parts[1];
endmodule

// File: rtl/lfsr_qpsk_src.sv
module lfsr_qpsk_src
  import lfsr_qpsk_pkg::*;
#(
  parameter int                 STATE_W    = 16,
  parameter int                 SAMPLE_W   = 16,
  parameter logic [STATE_W-1:0] TAPS       = 16'hB400,
  parameter logic [STATE_W-1:0] RESET_SEED = 16'hACE1,
  parameter int                 AMP        = 23170
) (
  input  logic                       clk,
  input  logic                       rst,
  input  logic                       seedLoad,
  input  logic [STATE_W-1:0]         seedValue,
  input  logic                       symReady,
  output logic                       symValid,
  output logic signed [SAMPLE_W-1:0] symI,
  output logic signed [SAMPLE_W-1:0] symQ
);
  lfsrCtl_t ctl;

  lfsr_qpsk_ctrl u_ctrl (
    .clk     (clk),
    .rst     (rst),
    .seedLoad(seedLoad),
    .symReady(symReady),
    .symValid(symValid),
    .ctl     (ctl)
  );

  lfsr_qpsk_dp #(
    .STATE_W   (STATE_W),
    .SAMPLE_W  (SAMPLE_W),
    .TAPS      (TAPS),
    .RESET_SEED(RESET_SEED),
    .AMP       (AMP)
  ) u_dp (
    .clk      (clk),
    .rst      (rst),
    .ctl      (ctl),
    .seedValue(seedValue),
    .symI     (symI),
    .symQ     (symQ)
  );
endmodule

// File: rtl/lfsr_qpsk_chk.sv
module lfsr_qpsk_chk #(
  parameter int SAMPLE_W = 16,
  parameter int AMP      = 23170
) (
  input logic                       clk,
  input logic                       rst,
  input logic                       seedLoad,
  input logic                       symReady,
  input logic                       symValid,
  input logic signed [SAMPLE_W-1:0] symI,
  input logic signed [SAMPLE_W-1:0] symQ
);
  localparam logic signed [SAMPLE_W-1:0] POS_LVL = SAMPLE_W'(AMP);
  localparam logic signed [SAMPLE_W-1:0] NEG_LVL = -POS_LVL;

  // R3
  levels_legal_chk: assert property (@(posedge clk) disable iff (rst)
    (symI == POS_LVL || symI == NEG_LVL) && (symQ == POS_LVL || symQ == NEG_LVL));

  // R2
  valid_after_reset_chk: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && !seedLoad) |-> symValid);

  // R6
  load_hides_valid_chk: assert property (@(posedge clk) disable iff (rst)
    seedLoad |-> !symValid);

  // R5
  hold_on_stall_chk: assert property (@(posedge clk) disable iff (rst)
    !(symValid && symReady) && !seedLoad |=> $stable(symI) && $stable(symQ));

  // R4
  shift_link_chk: assert property (@(posedge clk) disable iff (rst)
    symValid && symReady |=> symI == $past(symQ));
endmodule

bind lfsr_qpsk_src lfsr_qpsk_chk #(.SAMPLE_W(SAMPLE_W), .AMP(AMP)) u_chk (
  .clk     (clk),
  .rst     (rst),
  .seedLoad(seedLoad),
  .symReady(symReady),
  .symValid(symValid),
  .symI    (symI),
  .symQ    (symQ)
);

// File: tb/lfsr_qpsk_src_test.sv
module lfsr_qpsk_src_test;
  localparam int CLK_PERIOD = 10;
  localparam int LVL        = 23170;

  logic               clk = 1'b0;
  logic               rst = 1'b1;
  logic               seedLoad = 1'b0;
  logic [15:0]        seedValue = '0;
  logic               symReady = 1'b0;
  logic               symValid;
  logic signed [15:0] symI, symQ;

  lfsr_qpsk_src uut (
    .clk(clk), .rst(rst), .seedLoad(seedLoad), .seedValue(seedValue),
    .symReady(symReady), .symValid(symValid), .symI(symI), .symQ(symQ)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  typedef struct {
    bit                 skip;
    bit                 v;
    logic signed [15:0] i;
    logic signed [15:0] q;
    string              tag;
  } item_t;

  item_t sbq[$];
  int    checkCnt = 0;
  int    failCnt  = 0;

  // Independent model state, built from the requirements
  logic [15:0] mState = '0;
  bit          mValid = 1'b0;
  bit          known  = 1'b0;

  function automatic logic signed [15:0] mapBit(input logic b);
    return b ? -16'sd23170 : 16'sd23170;
  endfunction

  function automatic logic [15:0] stepOf(input logic [15:0] s);
    return {s[14:0], s[15] ^ s[13] ^ s[12] ^ s[10]};
  endfunction

  task automatic check(input bit ok, input string tag, input string what,
                       input int act, input int exp);
    checkCnt++;
    if (!ok) begin
      failCnt++;
      $display("FAIL %s %s: actual=%0d expected=%0d", tag, what, act, exp);
    end
  endtask

  // Driver: set one cycle of inputs, push what that cycle must show
  task automatic drive(input bit r, input bit ld, input logic [15:0] sd,
                       input bit rdy, input string tag);
    item_t it;
    @(posedge clk); #2;
    rst = r; seedLoad = ld; seedValue = sd; symReady = rdy;
    it.skip = !known;
    it.v    = mValid && !ld;
    it.i    = mapBit(mState[15]);
    it.q    = mapBit(mState[14]);
    it.tag  = tag;
    sbq.push_back(it);
    if (r) begin
      mState = 16'hACE1; mValid = 1'b0; known = 1'b1;
    end else begin
      if (ld)             mState = (sd == 16'h0) ? 16'h0001 : sd;
      else if (it.v && rdy) mState = stepOf(mState);
      mValid = 1'b1;
    end
  endtask

  // Monitor: compare at the falling edge
  initial begin
    forever begin
      @(negedge clk);
      if (sbq.size() > 0) begin
        item_t it;
        it = sbq.pop_front();
        if (!it.skip) begin
          check(symValid == it.v, it.tag, "symValid", int'(symValid), int'(it.v));
          if (it.v || !known || 1) begin
            check(symI == it.i, it.tag, "symI", int'(symI), int'(it.i));
            check(symQ == it.q, it.tag, "symQ", int'(symQ), int'(it.q));
          end
        end
      end
    end
  end

  initial begin
    #(CLK_PERIOD * 200000);
    checkCnt++; failCnt++;
    $display("FAIL watchdog: actual=%0d expected=%0d", 1, 0);
    $display("%0d/%0d checks passed", checkCnt - failCnt, checkCnt);
    $finish;
  end

  initial begin
    logic signed [15:0] startI, startQ;
    // R1: reset hold, then release
    repeat (3) drive(1, 0, 16'h0, 1, "R1");
    drive(0, 0, 16'h0, 1, "R1");
    // R2 R3 R4: free-running acceptance
    repeat (40) drive(0, 0, 16'h0, 1, "R4");
    // R5: stalls in a fixed pattern
    for (int n = 0; n < 30; n++) drive(0, 0, 16'h0, (n % 3) != 0, "R5");
    repeat (4) drive(0, 0, 16'h0, 0, "R5");
    // R6: load while ready is high, then run
    drive(0, 1, 16'h1234, 1, "R6");
    repeat (20) drive(0, 0, 16'h0, 1, "R6");
    // R6: load while stalled
    drive(0, 1, 16'h8001, 0, "R6");
    repeat (3) drive(0, 0, 16'h0, 0, "R6");
    repeat (10) drive(0, 0, 16'h0, 1, "R6");
    // R7: zero seed
    drive(0, 1, 16'h0000, 1, "R7");
    repeat (20) drive(0, 0, 16'h0, 1, "R7");
    // R9: reset together with a load
    drive(1, 1, 16'h5555, 1, "R9");
    drive(1, 1, 16'h5555, 1, "R9");
    drive(0, 0, 16'h0, 1, "R9");
    repeat (5) drive(0, 0, 16'h0, 1, "R9");
    // R8: full period from a known seed
    drive(0, 1, 16'hBEEF, 0, "R8");
    drive(0, 0, 16'h0, 0, "R8");
    @(negedge clk);
    startI = symI; startQ = symQ;
    repeat (65535) drive(0, 0, 16'h0, 1, "R8");
    drive(0, 0, 16'h0, 0, "R8");
    @(negedge clk);
    check(symI == startI, "R8", "wrap symI", int'(symI), int'(startI));
    check(symQ == startQ, "R8", "wrap symQ", int'(symQ), int'(startQ));
    repeat (3) @(negedge clk);
    check(sbq.size() == 0, "R4", "scoreboard drained", sbq.size(), 0);
    $display("%0d/%0d checks passed", checkCnt - failCnt, checkCnt);
    $finish;
  end
endmodule